// File: doc/BRIEF.md
# Serial ADC Conversion Sequencer

This block sits on the host side of a four-wire serial link to an eight-channel, 12-bit successive-approximation converter. It runs in SPI mode 0: the serial clock idles low, and both sides sample on the rising clock edge. When a conversion is requested, the block captures the channel, polarity, input-type and power/clock-mode settings and packs them into a command byte led by a start bit. It pulls the select line low and shifts the command out MSB first. It then waits for the converter's one-clock ready strobe and shifts in the 12-bit result that follows it, MSB first.

The serial clock comes from the system clock through a divider set by a parameter. A frame always runs at least 24 serial clocks, which is three byte transfers. If the strobe comes late, the frame grows just enough to collect all twelve result bits. If no strobe is seen by the fifteenth clock after the start bit, the frame is closed early and flagged as an error. Each frame ends with a single-cycle completion pulse that carries the result and the channel it belongs to. Requests that arrive while a frame is running are dropped.

Top module: `adc_host_ctrl`

## Requirements
- R1: After synchronous reset, chip select is high, the serial clock is low, the data-out line is low, and busy and done are low.
- R2: The command byte is sent MSB first with this layout: bit 7 is the start bit (1), bits 6:4 are the channel, bit 3 is 1 for unipolar, bit 2 is 1 for single-ended, and bits 1:0 are the power/clock mode.
- R3: Exactly LEAD_ZEROS zero bits are sent after chip select falls and before the start bit. The converter takes the first 1 it receives as the start bit.
- R4: The data-out line changes only on falling serial-clock edges while chip select is low. Strobe and result data are sampled on rising edges.
- R5: Each serial-clock high phase and low phase lasts HALF_DIV system clocks. Between frames the serial clock is low and chip select is high.
- R6: The strobe is accepted at any rising edge after the command byte and no later than the fifteenth rising edge counted from the start bit. The 12 result bits are taken on the 12 rising edges that follow the strobe, and any later bits are dropped.
- R7: A frame lasts LEAD_ZEROS plus the larger of 24 and (strobe edge + 12) rising edges. Edges are counted from the start bit.
- R8: If the strobe is not seen by the fifteenth edge after the start bit, the frame ends after that edge. Done then comes with err high and a result of zero.
- R9: Done is high for exactly one system clock, on the cycle that chip select returns high. It comes with the result, the channel of the frame, and err low on success.
- R10: A start request made while busy is ignored. It opens no new frame and produces no extra done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Conversion request, sampled while idle |
| chan | input | 3 | Channel to convert |
| unipolar | input | 1 | 1 selects unipolar coding |
| single_end | input | 1 | 1 selects single-ended input |
| pwr_mode | input | 2 | Power/clock mode field |
| busy | output | 1 | Frame in progress |
| cs_n | output | 1 | Chip select to converter, active low |
| sclk | output | 1 | Serial clock to converter |
| mosi | output | 1 | Command data to converter |
| miso | input | 1 | Result data from converter |
| strb | input | 1 | Converter ready strobe |
| done | output | 1 | One-cycle completion pulse |
| result | output | 12 | Converted value (zero on error) |
| res_chan | output | 3 | Channel of the completed frame |
| err | output | 1 | Strobe missing, valid with done |

## Verification
The checker watches the link rules on every cycle. It confirms that the serial clock stays low whenever chip select is high, that the data-out line moves only on falling clock edges, that done is a single cycle and coincides with chip select rising, that err is never raised without done, and that a request made while busy never pulls chip select low. The bench has to show the behaviours that depend on whole frames: command-byte content and leading-zero padding, alignment of the result after a strobe at varied delays, frame extension when the strobe is late, the early-closing error frame, and the exact high and low phase lengths of the divided clock.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;

    localparam int RES_W         = 12;
    localparam int CTRL_W        = 8;
    localparam int CH_W          = 3;
    localparam int FRAME_CLKS    = 24;
    localparam int STRB_DEADLINE = 15;
    localparam int RCNT_W        = $clog2(RES_W + 1);

    typedef struct packed {
        logic [CH_W-1:0] chan;
        logic            unipolar;
        logic            single_end;
        logic [1:0]      pmode;
    } conv_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_LAST = 2'd2
    } seq_state_t;

    function automatic logic [CTRL_W-1:0] build_ctrl(input conv_cfg_t c);
        return {1'b1, c.chan, c.unipolar, c.single_end, c.pmode};
    endfunction

endpackage

// File: rtl/adc_sclk_gen.sv
module adc_sclk_gen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic sclk,
    output logic rise,
    output logic fall
);
    logic tick;

    generate
        if (HALF_DIV <= 1) begin : g_nodiv
            assign tick = run;
        end else begin : g_div
            localparam int CW = $clog2(HALF_DIV);
            localparam logic [CW-1:0] CNT_TOP = CW'(HALF_DIV - 1);
            logic [CW-1:0] cnt;

            always_ff @(posedge clk) begin
                if (rst || !run) begin
                    cnt <= '0;
                end else if (cnt == CNT_TOP) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end

            assign tick = run && (cnt == CNT_TOP);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            sclk <= 1'b0;
        end else if (tick) begin
            sclk <= ~sclk;
        end
    end

    assign rise = tick && !sclk;
    assign fall = tick && sclk;

endmodule

// File: rtl/adc_tx_shift.sv
module adc_tx_shift
    import adc_ctrl_pkg::*;
#(
    parameter int LEAD_ZEROS = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [CTRL_W-1:0] ctrl_byte,
    input  logic              shift,
    output logic              mosi
);
    localparam int SW = LEAD_ZEROS + CTRL_W;

    logic [SW-1:0] sreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg <= '0;
        end else if (load) begin
            sreg <= SW'(ctrl_byte);
        end else if (shift) begin
            sreg <= {sreg[SW-2:0], 1'b0};
        end
    end

    assign mosi = sreg[SW-1];

endmodule

// File: rtl/adc_rx_capture.sv
module adc_rx_capture
    import adc_ctrl_pkg::*;
#(
    parameter int LEAD_ZEROS = 0,
    parameter int KW         = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             rise,
    input  logic [KW-1:0]    edge_no,
    input  logic             miso,
    input  logic             strb,
    output logic [RES_W-1:0] data,
    output logic             full_after,
    output logic             miss
);
    localparam logic [KW-1:0]     FIRST_STRB = KW'(LEAD_ZEROS + CTRL_W + 1);
    localparam logic [KW-1:0]     DEAD_EDGE  = KW'(LEAD_ZEROS + STRB_DEADLINE);
    localparam logic [RCNT_W-1:0] FULL       = RCNT_W'(RES_W);
    localparam logic [RCNT_W-1:0] FULL_M1    = RCNT_W'(RES_W - 1);

    logic              seen;
    logic [RCNT_W-1:0] nbits;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            seen  <= 1'b0;
            nbits <= '0;
            data  <= '0;
        end else if (rise) begin
            if (!seen) begin
                if (strb && edge_no >= FIRST_STRB) begin
                    seen <= 1'b1;
                end
            end else if (nbits != FULL) begin
                data  <= {data[RES_W-2:0], miso};
                nbits <= nbits + 1'b1;
            end
        end
    end

    assign miss       = rise && !seen && !strb && (edge_no == DEAD_EDGE);
    assign full_after = (nbits == FULL) || (seen && nbits == FULL_M1);

endmodule

// File: rtl/adc_host_ctrl.sv
module adc_host_ctrl
    import adc_ctrl_pkg::*;
#(
    parameter int HALF_DIV   = 2,
    parameter int LEAD_ZEROS = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CH_W-1:0]  chan,
    input  logic             unipolar,
    input  logic             single_end,
    input  logic [1:0]       pwr_mode,
    output logic             busy,
    output logic             cs_n,
    output logic             sclk,
    output logic             mosi,
    input  logic             miso,
    input  logic             strb,
    output logic             done,
    output logic [RES_W-1:0] result,
    output logic [CH_W-1:0]  res_chan,
    output logic             err
);
    localparam int KW = $clog2(LEAD_ZEROS + FRAME_CLKS + RES_W + 2);
    localparam logic [KW-1:0] MIN_LAST = KW'(LEAD_ZEROS + FRAME_CLKS);

    seq_state_t       st;
    conv_cfg_t        cfg_in;
    logic [CH_W-1:0]  chan_q;
    logic [KW-1:0]    rise_cnt;
    logic [KW-1:0]    edge_no;
    logic             run, rise, fall, load;
    logic             full_after, miss, last_rise, err_q;
    logic [RES_W-1:0] rx_data;

    assign cfg_in    = '{chan: chan, unipolar: unipolar, single_end: single_end, pmode: pwr_mode};
    assign run       = (st != ST_IDLE);
    assign busy      = run;
    assign load      = (st == ST_IDLE) && start;
    assign edge_no   = rise_cnt + 1'b1;
    assign last_rise = miss || ((edge_no >= MIN_LAST) && full_after);

    adc_sclk_gen #(.HALF_DIV(HALF_DIV)) u_clkgen (
        .clk (clk),
        .rst (rst),
        .run (run),
        .sclk(sclk),
        .rise(rise),
        .fall(fall)
    );

    adc_tx_shift #(.LEAD_ZEROS(LEAD_ZEROS)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .ctrl_byte(build_ctrl(cfg_in)),
        .shift    (fall),
        .mosi     (mosi)
    );

    adc_rx_capture #(.LEAD_ZEROS(LEAD_ZEROS), .KW(KW)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .clr       (load),
        .rise      (rise),
        .edge_no   (edge_no),
        .miso      (miso),
        .strb      (strb),
        .data      (rx_data),
        .full_after(full_after),
        .miss      (miss)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            cs_n     <= 1'b1;
            done     <= 1'b0;
            err      <= 1'b0;
            err_q    <= 1'b0;
            result   <= '0;
            res_chan <= '0;
            chan_q   <= '0;
            rise_cnt <= '0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (start) begin
                        chan_q   <= cfg_in.chan;
                        rise_cnt <= '0;
                        err_q    <= 1'b0;
                        cs_n     <= 1'b0;
                        st       <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (rise) begin
                        rise_cnt <= edge_no;
                        if (last_rise) begin
                            err_q <= miss;
                            st    <= ST_LAST;
                        end
                    end
                end
                ST_LAST: begin
                    if (fall) begin
                        st       <= ST_IDLE;
                        cs_n     <= 1'b1;
                        done     <= 1'b1;
                        err      <= err_q;
                        result   <= err_q ? '0 : rx_data;
                        res_chan <= chan_q;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/adc_ctrl_chk.sv
module adc_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic start,
    input logic busy,
    input logic cs_n,
    input logic sclk,
    input logic mosi,
    input logic done,
    input logic err
);
    AST_IDLE_SCLK_LOW: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sclk);  // R5

    AST_MOSI_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && $past(!cs_n) && !$stable(mosi)) |-> $fell(sclk));  // R4

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);  // R9

    AST_DONE_AT_CS_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |-> done);  // R9

    AST_ERR_ONLY_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        err |-> done);  // R8

    AST_BUSY_START_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (start && busy && !done) |=> !$fell(cs_n));  // R10

endmodule

bind adc_host_ctrl adc_ctrl_chk u_chk (
    .clk  (clk),
    .rst  (rst),
    .start(start),
    .busy (busy),
    .cs_n (cs_n),
    .sclk (sclk),
    .mosi (mosi),
    .done (done),
    .err  (err)
);

// File: tb/tb_adc_host_ctrl.sv
module tb_adc_host_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int HDIV       = 2;
    localparam int LEAD       = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  chan = '0;
    logic        unipolar = 1'b0;
    logic        single_end = 1'b0;
    logic [1:0]  pwr_mode = '0;
    logic        busy, cs_n, sclk, mosi, done, err;
    logic        miso = 1'b0;
    logic        strb = 1'b0;
    logic [11:0] result;
    logic [2:0]  res_chan;

    int checks = 0;
    int fails  = 0;

    // model controls and observations
    int          m_d = 0;
    bit          m_nostrb = 1'b0;
    logic [11:0] m_val = '0;
    logic [7:0]  m_byte;
    int          m_zeros;
    int          rise_total = 0;
    int          cs_fall_total = 0;
    int          hp_bad_total = 0;
    int          hi_cnt = 0;
    int          lo_cnt = 0;
    logic        sclk_prev = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_host_ctrl #(.HALF_DIV(HDIV), .LEAD_ZEROS(LEAD)) dut (
        .clk(clk), .rst(rst), .start(start), .chan(chan),
        .unipolar(unipolar), .single_end(single_end), .pwr_mode(pwr_mode),
        .busy(busy), .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso),
        .strb(strb), .done(done), .result(result), .res_chan(res_chan), .err(err)
    );

    always @(posedge sclk) rise_total++;
    always @(negedge cs_n) cs_fall_total++;

    // phase length monitor (R5)
    always @(posedge clk) begin
        if (rst || cs_n) begin
            hi_cnt <= 0;
            lo_cnt <= 0;
        end else begin
            if (sclk) begin
                if (!sclk_prev) begin
                    if (lo_cnt != HDIV) hp_bad_total <= hp_bad_total + 1;
                    lo_cnt <= 0;
                end
                hi_cnt <= hi_cnt + 1;
            end else begin
                if (sclk_prev) begin
                    if (hi_cnt != HDIV) hp_bad_total <= hp_bad_total + 1;
                    hi_cnt <= 0;
                end
                lo_cnt <= lo_cnt + 1;
            end
        end
        sclk_prev <= sclk;
    end

    // converter model
    initial begin
        forever begin
            bit   seen;
            int   nb;
            @(negedge cs_n);
            m_byte  = '0;
            m_zeros = 0;
            seen    = 1'b0;
            nb      = 0;
            while (nb < 8) begin
                @(posedge sclk);
                if (!seen && mosi) seen = 1'b1;
                if (seen) begin
                    m_byte = {m_byte[6:0], mosi};
                    nb++;
                end else begin
                    m_zeros++;
                end
            end
            if (!m_nostrb) begin
                repeat (m_d + 1) @(negedge sclk);
                strb = 1'b1;
                @(negedge sclk);
                strb = 1'b0;
                miso = m_val[11];
                for (int i = 10; i >= 0; i--) begin
                    @(negedge sclk);
                    miso = m_val[i];
                end
            end
            @(posedge cs_n);
            miso = 1'b0;
            strb = 1'b0;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input logic [2:0] ch, input logic u, input logic se,
                                            input logic [1:0] pm);
        return {1'b1, ch, u, se, pm};
    endfunction

    function automatic int exp_rises(input int d, input bit nostrb);
        int s;
        if (nostrb) return LEAD + 15;
        s = 9 + d;
        return LEAD + ((s + 12 > 24) ? s + 12 : 24);
    endfunction

    task automatic run_conv(input logic [2:0] ch, input logic u, input logic se,
                            input logic [1:0] pm, input int d, input bit nostrb,
                            input logic [11:0] val, input bit poke);
        int r0, c0, h0, n, dn;
        m_d = d; m_nostrb = nostrb; m_val = val;
        r0 = rise_total; c0 = cs_fall_total; h0 = hp_bad_total;
        @(negedge clk);
        chan = ch; unipolar = u; single_end = se; pwr_mode = pm; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (20) @(negedge clk);
            chan = ~ch; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        n = 0;
        while (!done && n < 3000) begin
            @(negedge clk);
            n++;
        end
        check(done == 1'b1, "R9 done seen", int'(done), 1);
        if (done) begin
            check(err == nostrb, "R8 err flag", int'(err), int'(nostrb));
            check(result == (nostrb ? 12'h000 : val), "R6 result", int'(result),
                  nostrb ? 0 : int'(val));
            check(res_chan == ch, "R9 channel", int'(res_chan), int'(ch));
            check(m_byte == exp_byte(ch, u, se, pm), "R2 command byte", int'(m_byte),
                  int'(exp_byte(ch, u, se, pm)));
            check(m_zeros == LEAD, "R3 leading zeros", m_zeros, LEAD);
            check(rise_total - r0 == exp_rises(d, nostrb), nostrb ? "R8 frame length" : "R7 frame length",
                  rise_total - r0, exp_rises(d, nostrb));
            check(hp_bad_total == h0, "R5 phase length", hp_bad_total - h0, 0);
            check(cs_n == 1'b1, "R9 cs high with done", int'(cs_n), 1);
            @(negedge clk);
            check(done == 1'b0, "R9 done one cycle", int'(done), 0);
            check(cs_n == 1'b1 && sclk == 1'b0, "R5 idle lines", int'({cs_n, sclk}), 2);
        end
        if (poke) begin
            dn = 0;
            repeat (150) begin
                @(negedge clk);
                if (done) dn++;
            end
            check(dn == 0, "R10 no extra done", dn, 0);
            check(cs_fall_total - c0 == 1, "R10 single frame", cs_fall_total - c0, 1);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R9 watchdog: actual=timeout expected=finish");
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        check(cs_n == 1'b1 && sclk == 1'b0 && mosi == 1'b0, "R1 reset lines",
              int'({cs_n, sclk, mosi}), 4);
        check(busy == 1'b0 && done == 1'b0, "R1 reset status", int'({busy, done}), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // directed corners
        run_conv(3'd7, 1'b1, 1'b1, 2'b11, 0, 1'b0, 12'hFFF, 1'b0);
        run_conv(3'd0, 1'b0, 1'b0, 2'b00, 0, 1'b0, 12'h000, 1'b0);
        run_conv(3'd5, 1'b1, 1'b0, 2'b01, 3, 1'b0, 12'hA5C, 1'b0);
        run_conv(3'd2, 1'b0, 1'b1, 2'b10, 6, 1'b0, 12'h801, 1'b0);
        run_conv(3'd4, 1'b1, 1'b1, 2'b11, 0, 1'b1, 12'h123, 1'b0);
        run_conv(3'd1, 1'b1, 1'b1, 2'b11, 2, 1'b0, 12'h3C7, 1'b1);

        // constrained random
        for (int k = 0; k < 40; k++) begin
            logic [2:0]  rc;
            logic [1:0]  rp;
            logic [11:0] rv;
            rc = 3'($urandom % 8);
            rp = 2'($urandom % 4);
            rv = 12'($urandom % 4096);
            run_conv(rc, 1'($urandom % 2), 1'($urandom % 2), rp, int'($urandom % 7),
                     ($urandom % 8) == 0, rv, 1'b0);
        end

        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule